// File: doc/BRIEF.md
# Local Exclusive Access Monitor

This block holds the one-bit reservation a processor core keeps between an exclusive load and the exclusive store that should follow it. An exclusive load opens a reservation and records the address and access size it used. An exclusive store is judged in the cycle it is presented. It may write memory only while a reservation is held for the same address and size, no clear event is present, and the bus-level monitor reports no exclusive failure in that cycle. The block answers at once with a write enable that gates the memory write strobe and a one-bit status value for the core's destination register.

Two events drop the reservation: an explicit clear command and an exception entry or exit pulse. Any exclusive store, whether it passes or fails, also drops it. None of these pins carries a data stream, so all of them are plain level or pulse pins sampled on the rising clock edge. There is no back-pressure: the store verdict is combinational from the store request in the same cycle. Access size is encoded as 0 = byte, 1 = halfword, 2 = word.

Top module: `excl_monitor`

## Requirements
- R1: After reset the reservation is dropped. While no store is requested, `wr_en` and `st_status` are 0.
- R2: An exclusive store to the same address and size as the last exclusive load, with no later clear, exception or store, and with `bus_fail` low, gives `wr_en`=1 and `st_status`=0 in its own cycle.
- R3: An exclusive store with no reservation held, including one with no exclusive load since reset, gives `wr_en`=0 and `st_status`=1 in its own cycle.
- R4: When `bus_fail` is high in the cycle of a store, the store fails (`wr_en`=0, `st_status`=1) even if a reservation is held.
- R5: `clr_cmd` drops the reservation. A store in the same cycle as `clr_cmd`, or in any later cycle before a new load, fails.
- R6: `exc_event` drops the reservation. A store in the same cycle as `exc_event`, or in any later cycle before a new load, fails.
- R7: Every exclusive store drops the reservation, so a second store with no load in between fails.
- R8: A store whose address or size (0 = byte, 1 = halfword, 2 = word) differs from those recorded by the last load fails.
- R9: A load in the same cycle as `clr_cmd` or `exc_event` leaves no reservation. The clear wins.
- R10: A load in the same cycle as a store sets a fresh reservation for the load's address and size. The store in that cycle is judged on the state before the load.
- R11: A new load replaces the recorded address and size. A store to the earlier load's address then fails.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| ld_req | input | 1 | Exclusive load strobe |
| ld_addr | input | ADDR_W | Exclusive load address |
| ld_size | input | 2 | Exclusive load size (0 byte, 1 half, 2 word) |
| st_req | input | 1 | Exclusive store strobe |
| st_addr | input | ADDR_W | Exclusive store address |
| st_size | input | 2 | Exclusive store size |
| clr_cmd | input | 1 | Explicit clear-reservation command |
| exc_event | input | 1 | Exception entry or exit pulse |
| bus_fail | input | 1 | Bus-level exclusive failure for the current store |
| wr_en | output | 1 | Memory write strobe gate for the store |
| st_status | output | 1 | Store result: 0 success, 1 failure (0 when no store) |

## Verification
The pairs that can collide in one cycle are a store with a clear or exception pulse, and a load with either a clear pulse or a store. Random traffic over a small address pool fires loads, stores, clears, exceptions and bus failures independently, so these overlaps occur often. Directed steps also force each overlap on purpose. A bench model applies the stated priority (clear over load over store-drop), judges each store on the state held before its cycle, and compares both outputs in that same cycle.

// File: rtl/excl_monitor_pkg.sv
package excl_monitor_pkg;
  localparam int SIZE_W = 2;
  typedef enum logic [SIZE_W-1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_RSVD = 2'd3
  } acc_size_e;
endpackage

// File: rtl/excl_resv_bit.sv
module excl_resv_bit (
  input  logic clk,
  input  logic rst_n,
  input  logic kill,
  input  logic ld_req,
  input  logic st_req,
  output logic held
);
  logic held_q;

  always_ff @(posedge clk) begin
    if (!rst_n)      held_q <= 1'b0;
    else if (kill)   held_q <= 1'b0;
    else if (ld_req) held_q <= 1'b1;
    else if (st_req) held_q <= 1'b0;
  end

  assign held = held_q;
endmodule

// File: rtl/excl_tag.sv
module excl_tag
  import excl_monitor_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter bit MATCH_ADDR = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ld_req,
  input  logic [ADDR_W-1:0] ld_addr,
  input  logic [SIZE_W-1:0] ld_size,
  input  logic [ADDR_W-1:0] st_addr,
  input  logic [SIZE_W-1:0] st_size,
  output logic              hit
);
  localparam int TAG_W = ADDR_W + SIZE_W;

  generate
    if (MATCH_ADDR) begin : g_tag
      logic [TAG_W-1:0] tag_q;
      always_ff @(posedge clk) begin
        if (!rst_n)      tag_q <= '0;
        else if (ld_req) tag_q <= {ld_addr, ld_size};
      end
      assign hit = (tag_q == {st_addr, st_size});
    end else begin : g_notag
      assign hit = 1'b1;
    end
  endgenerate
endmodule

// File: rtl/excl_judge.sv
module excl_judge (
  input  logic st_req,
  input  logic held,
  input  logic hit,
  input  logic kill,
  input  logic bus_fail,
  output logic wr_en,
  output logic st_status
);
  logic pass;

  always_comb begin
    pass      = held && hit && !kill && !bus_fail;
    wr_en     = st_req && pass;
    st_status = st_req && !pass;
  end
endmodule

// File: rtl/excl_monitor.sv
module excl_monitor
  import excl_monitor_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter bit MATCH_ADDR = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ld_req,
  input  logic [ADDR_W-1:0] ld_addr,
  input  logic [1:0]        ld_size,
  input  logic              st_req,
  input  logic [ADDR_W-1:0] st_addr,
  input  logic [1:0]        st_size,
  input  logic              clr_cmd,
  input  logic              exc_event,
  input  logic              bus_fail,
  output logic              wr_en,
  output logic              st_status
);
  logic kill;
  logic held;
  logic hit;

  assign kill = clr_cmd | exc_event;

  excl_resv_bit u_resv (
    .clk    (clk),
    .rst_n  (rst_n),
    .kill   (kill),
    .ld_req (ld_req),
    .st_req (st_req),
    .held   (held)
  );

  excl_tag #(
    .ADDR_W     (ADDR_W),
    .MATCH_ADDR (MATCH_ADDR)
  ) u_tag (
    .clk     (clk),
    .rst_n   (rst_n),
    .ld_req  (ld_req),
    .ld_addr (ld_addr),
    .ld_size (ld_size),
    .st_addr (st_addr),
    .st_size (st_size),
    .hit     (hit)
  );

  excl_judge u_judge (
    .st_req    (st_req),
    .held      (held),
    .hit       (hit),
    .kill      (kill),
    .bus_fail  (bus_fail),
    .wr_en     (wr_en),
    .st_status (st_status)
  );
endmodule

// File: rtl/excl_monitor_chk.sv
module excl_monitor_chk (
  input logic clk,
  input logic rst_n,
  input logic ld_req,
  input logic st_req,
  input logic clr_cmd,
  input logic exc_event,
  input logic bus_fail,
  input logic wr_en,
  input logic st_status
);
  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !st_req |-> (!wr_en && !st_status));

  p_verdict_split_r2: assert property (@(posedge clk) disable iff (!rst_n)
    st_req |-> (wr_en != st_status));

  p_bus_fail_blocks_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (st_req && bus_fail) |-> (st_status && !wr_en));

  p_clear_same_cycle_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (st_req && clr_cmd) |-> !wr_en);

  p_exc_same_cycle_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (st_req && exc_event) |-> !wr_en);

  p_clear_prev_cycle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (st_req && $past(clr_cmd || exc_event)) |-> !wr_en);

  p_store_drops_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (st_req && $past(st_req) && !$past(ld_req)) |-> !wr_en);
endmodule

bind excl_monitor excl_monitor_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .ld_req    (ld_req),
  .st_req    (st_req),
  .clr_cmd   (clr_cmd),
  .exc_event (exc_event),
  .bus_fail  (bus_fail),
  .wr_en     (wr_en),
  .st_status (st_status)
);

// File: tb/excl_monitor_test.sv
module excl_monitor_test;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ld_req = 1'b0, st_req = 1'b0, clr_cmd = 1'b0, exc_event = 1'b0, bus_fail = 1'b0;
  logic [AW-1:0] ld_addr = '0, st_addr = '0;
  logic [1:0] ld_size = '0, st_size = '0;
  logic wr_en, st_status;

  int checks = 0;
  int failures = 0;
  bit m_held = 1'b0;
  logic [AW-1:0] m_addr = '0;
  logic [1:0] m_size = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  excl_monitor #(.ADDR_W(AW)) uut (
    .clk(clk), .rst_n(rst_n),
    .ld_req(ld_req), .ld_addr(ld_addr), .ld_size(ld_size),
    .st_req(st_req), .st_addr(st_addr), .st_size(st_size),
    .clr_cmd(clr_cmd), .exc_event(exc_event), .bus_fail(bus_fail),
    .wr_en(wr_en), .st_status(st_status)
  );

  function automatic bit exp_pass(bit held, logic [AW-1:0] ta, logic [1:0] ts,
                                  logic [AW-1:0] sa, logic [1:0] ss,
                                  bit clr, bit exc, bit bf);
    return held && (ta == sa) && (ts == ss) && !clr && !exc && !bf;
  endfunction

  task automatic check(string req, logic act_wr, logic act_st, bit ewr, bit est);
    checks++;
    if (act_wr !== ewr || act_st !== est) begin
      failures++;
      $display("FAIL %s: wr_en=%b st_status=%b expected wr_en=%b st_status=%b",
               req, act_wr, act_st, ewr, est);
    end
  endtask

  task automatic step(string req, bit l, logic [AW-1:0] la, logic [1:0] ls,
                      bit s, logic [AW-1:0] sa, logic [1:0] ss,
                      bit c, bit e, bit f);
    bit p;
    @(negedge clk);
    ld_req = l; ld_addr = la; ld_size = ls;
    st_req = s; st_addr = sa; st_size = ss;
    clr_cmd = c; exc_event = e; bus_fail = f;
    #1;
    p = exp_pass(m_held, m_addr, m_size, sa, ss, c, e, f);
    check(req, wr_en, st_status, s && p, s && !p);
    if (c || e) m_held = 1'b0;
    else if (l) begin m_held = 1'b1; m_addr = la; m_size = ls; end
    else if (s) m_held = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 190000);
    failures++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED_0042));
    repeat (3) @(negedge clk);
    #1 check("R1 reset", wr_en, st_status, 1'b0, 1'b0);
    @(negedge clk) rst_n = 1'b1;
    // R1 idle, R3 store with no load since reset
    step("R1 idle", 0, 0, 0, 0, 0, 0, 0, 0, 0);
    step("R3 no load", 0, 0, 0, 1, 32'h100, 2, 0, 0, 0);
    // R2 basic success, R7 second store fails
    step("R2 load", 1, 32'h100, 2, 0, 0, 0, 0, 0, 0);
    step("R2 store ok", 0, 0, 0, 1, 32'h100, 2, 0, 0, 0);
    step("R7 store again", 0, 0, 0, 1, 32'h100, 2, 0, 0, 0);
    // R4 bus fail
    step("R4 load", 1, 32'h40, 0, 0, 0, 0, 0, 0, 0);
    step("R4 bus fail", 0, 0, 0, 1, 32'h40, 0, 0, 0, 1);
    // R5 clear between and same cycle
    step("R5 load", 1, 32'h80, 1, 0, 0, 0, 0, 0, 0);
    step("R5 clear", 0, 0, 0, 0, 0, 0, 1, 0, 0);
    step("R5 store after clear", 0, 0, 0, 1, 32'h80, 1, 0, 0, 0);
    step("R5 load", 1, 32'h80, 1, 0, 0, 0, 0, 0, 0);
    step("R5 store with clear", 0, 0, 0, 1, 32'h80, 1, 1, 0, 0);
    // R6 exception between and same cycle
    step("R6 load", 1, 32'h84, 2, 0, 0, 0, 0, 0, 0);
    step("R6 exception", 0, 0, 0, 0, 0, 0, 0, 1, 0);
    step("R6 store after exc", 0, 0, 0, 1, 32'h84, 2, 0, 0, 0);
    step("R6 load", 1, 32'h84, 2, 0, 0, 0, 0, 0, 0);
    step("R6 store with exc", 0, 0, 0, 1, 32'h84, 2, 0, 1, 0);
    // R8 address and size mismatch
    step("R8 load", 1, 32'h200, 2, 0, 0, 0, 0, 0, 0);
    step("R8 addr mismatch", 0, 0, 0, 1, 32'h204, 2, 0, 0, 0);
    step("R8 load", 1, 32'h200, 2, 0, 0, 0, 0, 0, 0);
    step("R8 size mismatch", 0, 0, 0, 1, 32'h200, 0, 0, 0, 0);
    // R9 load with clear / exception
    step("R9 load+clear", 1, 32'h300, 2, 0, 0, 0, 1, 0, 0);
    step("R9 store", 0, 0, 0, 1, 32'h300, 2, 0, 0, 0);
    step("R9 load+exc", 1, 32'h300, 2, 0, 0, 0, 0, 1, 0);
    step("R9 store", 0, 0, 0, 1, 32'h300, 2, 0, 0, 0);
    // R10 load together with store
    step("R10 load+store", 1, 32'h400, 1, 1, 32'h400, 1, 0, 0, 0);
    step("R10 store ok", 0, 0, 0, 1, 32'h400, 1, 0, 0, 0);
    // R11 reload replaces tag
    step("R11 load A", 1, 32'h500, 2, 0, 0, 0, 0, 0, 0);
    step("R11 load B", 1, 32'h600, 2, 0, 0, 0, 0, 0, 0);
    step("R11 store A", 0, 0, 0, 1, 32'h500, 2, 0, 0, 0);
    step("R11 load B", 1, 32'h600, 2, 0, 0, 0, 0, 0, 0);
    step("R11 store B", 0, 0, 0, 1, 32'h600, 2, 0, 0, 0);
    // random mix: R2 R3 R4 R5 R6 R7 R8 R9 R10
    for (int i = 0; i < 4000; i++) begin
      bit l, s, c, e, f;
      logic [AW-1:0] la, sa;
      logic [1:0] ls, ss;
      l = ($urandom % 3) == 0;
      s = ($urandom % 2) == 0;
      c = ($urandom % 12) == 0;
      e = ($urandom % 12) == 0;
      f = ($urandom % 8) == 0;
      la = 32'h1000 + 4 * ($urandom % 3);
      sa = 32'h1000 + 4 * ($urandom % 3);
      ls = 2'($urandom % 3);
      ss = (($urandom % 4) == 0) ? 2'($urandom % 3) : m_size;
      step("R2-mix random", l, la, ls, s, sa, ss, c, e, f);
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule